// File: doc/BRIEF.md
# Composite Sync Separator and Normalizer

This block accepts a digital horizontal or composite sync signal, of either polarity, sampled on a fast system clock. It learns which level is the active one and flips the signal so that the active level is always high. It then checks each active run against a minimum width. For each valid line it produces a single-cycle horizontal strobe that marks the pulse's leading edge, after a fixed latency. Qualified pulses that arrive well before the next line is due are dropped. These are equalization and serration pulses, and dropping them means a downstream phase comparator sees exactly one strobe per line.

The same per-line measurement recovers the vertical interval from composite sync. Each line window counts its active cycles. A line whose active share is above one quarter of its length counts as over-threshold. The vertical output follows the over/under classification with a two-line debounce.

A polarity status bit reports which level was found to be active. Any change of polarity restarts the line measurement from scratch.

Top module: `csync_sep`

## Requirements
- R1: After reset `hstrobe_o`, `vsync_o` and `pol_low_o` are 0. No strobe is produced until a line period has been measured. The first qualifying pulse only sets the timing reference, and the second qualifying pulse gives the first strobe.
- R2: An active run shorter than `MIN_W` cycles is ignored: it produces no strobe and does not shift later strobes. A run of exactly `MIN_W` cycles qualifies.
- R3: Each strobe is high for one cycle only. It appears `MIN_W + SYNC_STAGES` clock cycles after the cycle in which the input first shows its active level.
- R4: A qualifying pulse whose leading edge comes less than three quarters of the measured period after the last accepted edge produces no strobe. It also leaves the period and the next strobe time unchanged.
- R5: When more than 1.5 measured periods pass between accepted edges, the late pulse becomes a new reference and gives no strobe. The next qualifying pulse gives a strobe again.
- R6: At each rising edge of the synchronized input, the polarity is updated from the cycles counted since the previous rising edge. If the high time is under a quarter of that span, the active level is high (`pol_low_o` = 0). Otherwise, if the low time is under a quarter, the active level is low (`pol_low_o` = 1). Otherwise the polarity is unchanged.
- R7: A polarity change clears the line measurement. No strobe appears in the cycle after the change, and strobes resume only at the second qualifying pulse after it.
- R8: A line window runs from one accepted edge to the next. It is over-threshold when its active-cycle count exceeds a quarter of its length in cycles.
- R9: `vsync_o` rises on the second consecutive over-threshold line and falls on the second consecutive under-threshold line. It changes only in the same cycle as a strobe.
- R10: With an active-low input, the falling edge is the leading edge, and strobe latency and line gating are the same as for active-high input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | Raw horizontal or composite sync, either polarity |
| hstrobe_o | output | 1 | One-cycle strobe per accepted line |
| vsync_o | output | 1 | Extracted vertical interval, active high |
| pol_low_o | output | 1 | 1 when the input's active level is low |

## Verification
The horizontal strobe and a change of the vertical output fall in the same cycle: `vsync_o` switches exactly on the strobe that closes the second line of a new duty class. The bench provokes this by switching from narrow line pulses to four wide ones and back. Every expected strobe carries both its cycle number and the vertical level predicted from a line-duty model. A strobe that arrives on time with the wrong vertical level, or a vertical change one cycle away from its strobe, is therefore reported. Equalization pulses, glitches and a polarity switch are mixed into the same run, so that suppression and the vertical debounce are judged against the same stream of strobes.

// File: rtl/csync_pkg.sv
// Package: shared types for the composite sync separator.
// Assumes: nothing beyond SystemVerilog 2017.
package csync_pkg;

    // Which input level carries the sync pulse
    typedef enum logic {
        POL_ACT_HIGH = 1'b0,
        POL_ACT_LOW  = 1'b1
    } pol_e;

    // One accepted line boundary with its duty class
    typedef struct packed {
        logic valid;
        logic over;
    } line_evt_t;

endpackage

// File: rtl/csync_sync.sv
// Module: input synchronizer with a one-cycle delayed copy for edge detection.
// Assumes: STAGES >= 1; the input is asynchronous to clk.
module csync_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic q_o,
    output logic q_d_o
);

    logic [STAGES-1:0] stg_q;
    logic              dly_q;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= din;
            end
        end else begin : g_chain
            // Shift chain of capture flops
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= {stg_q[STAGES-2:0], din};
            end
        end
    endgenerate

    // Delayed copy used by the edge detectors downstream
    always_ff @(posedge clk) begin
        if (!rst_n) dly_q <= 1'b0;
        else        dly_q <= stg_q[STAGES-1];
    end

    assign q_o   = stg_q[STAGES-1];
    assign q_d_o = dly_q;

endmodule

// File: rtl/csync_polarity.sv
// Module: polarity learner and normalizer.
// Measures the high time between consecutive rising edges of the synchronized
// input, decides which level is active (< 1/4 of the span), and produces a
// positive-going active signal. Flags a one-cycle change pulse on any flip.
// Assumes: raw_d_i is raw_i delayed by one clock.
module csync_polarity
    import csync_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic raw_d_i,
    output logic act_o,
    output pol_e pol_o,
    output logic chg_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, hi_q, lo_w;
    logic [CNT_W+1:0] hi4_w, lo4_w, tot_w;
    logic             seen_q, chg_q, rise_w;
    pol_e             pol_q, pol_nx;

    assign rise_w = raw_i & ~raw_d_i;

    // Decide the active level from the span that just ended
    always_comb begin
        lo_w   = cnt_q - hi_q;
        hi4_w  = {hi_q, 2'b00};
        lo4_w  = {lo_w, 2'b00};
        tot_w  = {2'b00, cnt_q};
        pol_nx = pol_q;
        if (hi4_w < tot_w)      pol_nx = POL_ACT_HIGH;
        else if (lo4_w < tot_w) pol_nx = POL_ACT_LOW;
    end

    // Span counters, polarity register and change pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hi_q   <= '0;
            seen_q <= 1'b0;
            pol_q  <= POL_ACT_HIGH;
            chg_q  <= 1'b0;
        end else begin
            chg_q <= 1'b0;
            if (rise_w) begin
                cnt_q  <= CNT_ONE;
                hi_q   <= CNT_ONE;
                seen_q <= 1'b1;
                if (seen_q) begin
                    pol_q <= pol_nx;
                    chg_q <= (pol_nx != pol_q);
                end
            end else begin
                if (cnt_q != CNT_TOP) cnt_q <= cnt_q + CNT_ONE;
                if (raw_i && hi_q != CNT_TOP) hi_q <= hi_q + CNT_ONE;
            end
        end
    end

    assign act_o = raw_i ^ (pol_q == POL_ACT_LOW);
    assign pol_o = pol_q;
    assign chg_o = chg_q;

    AST_POL_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(pol_q) |-> $past(rise_w)); // R6

endmodule

// File: rtl/csync_line.sv
// Module: line timing core.
// Qualifies active runs of at least MIN_W cycles, measures the period between
// accepted edges, suppresses edges earlier than 3/4 period, restarts after a
// gap above 1.5 periods, and emits a one-cycle strobe plus a line event that
// carries the window's duty class (active count > window/4).
// Assumes: act_i is positive-going; clr_i is a synchronous restart request.
module csync_line
    import csync_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int MIN_W = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr_i,
    input  logic      act_i,
    output logic      strobe_o,
    output line_evt_t evt_o
);

    localparam int               RUN_W    = $clog2(MIN_W + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(MIN_W - 1);
    localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(MIN_W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TOP  = {CNT_W{1'b1}};

    logic [RUN_W-1:0] run_q;
    logic [CNT_W-1:0] since_q, period_q, acc_q, thr_w;
    logic [CNT_W:0]   lim_w;
    logic             have_ref_q, valid_q, strobe_q;
    logic             qual_w, early_w, late_w;
    logic             take_ref, take_first, take_lost, take_line;

    // Classify the current cycle's qualification against the measured period
    always_comb begin
        thr_w      = period_q - (period_q >> 2);
        lim_w      = {1'b0, period_q} + {2'b00, period_q[CNT_W-1:1]};
        qual_w     = act_i && (run_q == RUN_LAST);
        early_w    = since_q < thr_w;
        late_w     = {1'b0, since_q} > lim_w;
        take_ref   = qual_w && !have_ref_q;
        take_first = qual_w && have_ref_q && !valid_q;
        take_lost  = qual_w && valid_q && late_w;
        take_line  = qual_w && valid_q && !late_w && !early_w;
        evt_o.valid = (take_first || take_line) && !clr_i;
        evt_o.over  = acc_q > (since_q >> 2);
    end

    // Run, window and period registers
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            run_q      <= '0;
            since_q    <= '0;
            period_q   <= '0;
            acc_q      <= '0;
            have_ref_q <= 1'b0;
            valid_q    <= 1'b0;
            strobe_q   <= 1'b0;
        end else begin
            if (!act_i)               run_q <= '0;
            else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
            if (since_q != CNT_TOP) since_q <= since_q + CNT_ONE;
            if (act_i && acc_q != CNT_TOP) acc_q <= acc_q + CNT_ONE;
            strobe_q <= take_first || take_line;
            if (take_ref) begin
                have_ref_q <= 1'b1;
                since_q    <= CNT_ONE;
                acc_q      <= '0;
            end
            if (take_first) begin
                valid_q  <= 1'b1;
                period_q <= since_q;
                since_q  <= CNT_ONE;
                acc_q    <= '0;
            end
            if (take_lost) begin
                valid_q <= 1'b0;
                since_q <= CNT_ONE;
                acc_q   <= '0;
            end
            if (take_line) begin
                period_q <= since_q;
                since_q  <= CNT_ONE;
                acc_q    <= '0;
            end
        end
    end

    assign strobe_o = strobe_q;

    AST_STROBE_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) strobe_q |=> !strobe_q);       // R3
    AST_STROBE_MEASURED: assert property (@(posedge clk) disable iff (!rst_n) strobe_q |-> valid_q);         // R1
    AST_STROBE_ACTIVE:   assert property (@(posedge clk) disable iff (!rst_n) strobe_q |-> $past(act_i));    // R2

endmodule

// File: rtl/csync_vert.sv
// Module: vertical interval filter.
// Follows the per-line duty class with a two-line debounce: the output flips
// only after two consecutive line events that disagree with it.
// Assumes: evt_i.valid is high for one cycle per accepted line.
module csync_vert
    import csync_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  line_evt_t evt_i,
    output logic      vsync_o
);

    logic vs_q, pend_q;

    // Debounce the duty class across line events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q   <= 1'b0;
            pend_q <= 1'b0;
        end else if (evt_i.valid) begin
            if (evt_i.over != vs_q) begin
                if (pend_q) begin
                    vs_q   <= evt_i.over;
                    pend_q <= 1'b0;
                end else begin
                    pend_q <= 1'b1;
                end
            end else begin
                pend_q <= 1'b0;
            end
        end
    end

    assign vsync_o = vs_q;

    AST_VERT_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rst_n) !$stable(vs_q) |-> $past(pend_q)); // R9

endmodule

// File: rtl/csync_sep.sv
// Module: composite sync separator top.
// Chain: synchronizer -> polarity normalizer -> line timing core -> vertical filter.
// Assumes: sync_in is a digital sync of either polarity; MIN_W >= 1.
module csync_sep
    import csync_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int MIN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic hstrobe_o,
    output logic vsync_o,
    output logic pol_low_o
);

    logic      raw_w, raw_d_w, act_w, chg_w, strobe_w, vs_w;
    pol_e      pol_w;
    line_evt_t evt_w;

    csync_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sync_in),
        .q_o   (raw_w),
        .q_d_o (raw_d_w)
    );

    csync_polarity #(.CNT_W(CNT_W)) u_pol (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (raw_w),
        .raw_d_i (raw_d_w),
        .act_o   (act_w),
        .pol_o   (pol_w),
        .chg_o   (chg_w)
    );

    csync_line #(.CNT_W(CNT_W), .MIN_W(MIN_W)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (chg_w),
        .act_i    (act_w),
        .strobe_o (strobe_w),
        .evt_o    (evt_w)
    );

    csync_vert u_vert (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_w),
        .vsync_o (vs_w)
    );

    assign hstrobe_o = strobe_w;
    assign vsync_o   = vs_w;
    assign pol_low_o = (pol_w == POL_ACT_LOW);

    AST_VERT_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(vs_w) |-> strobe_w);   // R9
    AST_POL_RESTART:      assert property (@(posedge clk) disable iff (!rst_n) !$stable(pol_w) |=> !strobe_w); // R7

endmodule

// File: tb/csync_sep_tb.sv
// Scoreboard bench: the pulse driver predicts each strobe (cycle and vertical
// level) into a queue; a monitor pops and compares on every observed strobe.
module csync_sep_tb_top;

    localparam int MIN_W = 8;
    localparam int SYNC  = 2;
    localparam int LAT   = MIN_W + SYNC;
    localparam int K_IGN = 0;
    localparam int K_REF = 1;
    localparam int K_STB = 2;

    typedef struct {
        int    cyc;
        bit    vert;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_in = 1'b0;
    logic hstrobe_o, vsync_o, pol_low_o;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    bit   act_lvl = 1'b1;
    exp_t q[$];

    // model state
    int line_act = 0;
    int len_since = 0;
    bit vm = 1'b0;
    bit pend = 1'b0;

    csync_sep #(.CNT_W(16), .MIN_W(MIN_W), .SYNC_STAGES(SYNC)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .hstrobe_o (hstrobe_o),
        .vsync_o   (vsync_o),
        .pol_low_o (pol_low_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        line_act  = 0;
        len_since = 0;
        vm   = 1'b0;
        pend = 1'b0;
    endtask

    // Drive one pulse of width w starting a span of len cycles; predict outcome
    task automatic emit(input int w, input int len, input int kind, input string req);
        int  lead;
        bit  over;
        exp_t e;
        lead = cyc;
        if (kind == K_STB) begin
            over = (line_act * 4) > len_since;        // R8 duty rule
            if (over != vm) begin                      // R9 two-line debounce
                if (pend) begin vm = over; pend = 1'b0; end
                else pend = 1'b1;
            end else begin
                pend = 1'b0;
            end
            e.cyc = lead + LAT; e.vert = vm; e.req = req;
            q.push_back(e);
            line_act = w; len_since = len;
        end else if (kind == K_REF) begin
            line_act = w; len_since = len;
        end else begin
            line_act += w; len_since += len;
        end
        sync_in = act_lvl;
        repeat (w) @(negedge clk);
        sync_in = ~act_lvl;
        repeat (len - w) @(negedge clk);
    endtask

    // Monitor: compare each observed strobe against the scoreboard
    always @(negedge clk) begin
        if (rst_n && hstrobe_o === 1'b1) begin
            checks++;
            if (q.size() == 0) begin
                failures++;
                $display("FAIL R3 unexpected strobe: actual=cycle %0d expected=none", cyc);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.cyc != cyc || e.vert != vsync_o) begin
                    failures++;
                    $display("FAIL %s strobe: actual=cycle %0d vert %0b expected=cycle %0d vert %0b",
                             e.req, cyc, vsync_o, e.cyc, e.vert);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        act_lvl = 1'b1;
        sync_in = 1'b0;
        do_reset();
        chk("R1", hstrobe_o, 0, "strobe after reset");
        chk("R1", vsync_o, 0, "vsync after reset");
        chk("R1", pol_low_o, 0, "polarity after reset");
        repeat (20) @(negedge clk);

        // Active-high lines, period 200
        emit(16, 200, K_REF, "R1");
        emit(16, 200, K_STB, "R1");
        emit(16, 200, K_STB, "R3");
        emit(16, 200, K_STB, "R3");
        // Short glitch mid-line
        emit(16, 100, K_STB, "R3");
        emit(7,  100, K_IGN, "R2");
        emit(16, 200, K_STB, "R2");
        // Qualifying pulse at half line is suppressed
        emit(16, 100, K_STB, "R3");
        emit(8,  100, K_IGN, "R4");
        emit(16, 200, K_STB, "R4");
        // Equalization-style burst of MIN_W-wide pulses at twice line rate
        emit(8, 100, K_STB, "R2");
        emit(8, 100, K_IGN, "R4");
        emit(8, 100, K_STB, "R4");
        emit(8, 100, K_IGN, "R4");
        emit(16, 200, K_STB, "R4");
        chk("R6", pol_low_o, 0, "polarity with narrow high pulses");
        // Missing lines
        emit(16, 600, K_STB, "R3");
        emit(16, 200, K_REF, "R5");
        emit(16, 200, K_STB, "R5");
        emit(16, 200, K_STB, "R5");
        // Vertical interval: wide pulses then back to narrow
        emit(80, 200, K_STB, "R8");
        emit(80, 200, K_STB, "R8");
        emit(80, 200, K_STB, "R9");
        emit(80, 200, K_STB, "R9");
        emit(16, 200, K_STB, "R9");
        emit(16, 200, K_STB, "R9");
        emit(16, 200, K_STB, "R9");
        emit(16, 200, K_STB, "R9");
        chk("R6", pol_low_o, 0, "polarity unchanged by 40% pulses");
        chk("R9", vsync_o, 0, "vsync after narrow lines");

        // Active-low input after a fresh reset
        act_lvl = 1'b0;
        sync_in = 1'b1;
        do_reset();
        repeat (200) @(negedge clk);
        emit(16, 200, K_IGN, "R6");
        chk("R6", pol_low_o, 1, "polarity learned as active-low");
        emit(16, 200, K_REF, "R7");
        emit(16, 200, K_STB, "R7");
        emit(16, 200, K_STB, "R10");
        emit(16, 200, K_STB, "R10");
        chk("R10", pol_low_o, 1, "polarity holds active-low");

        repeat (LAT + 5) @(negedge clk);
        chk("R3", q.size(), 0, "strobes still outstanding");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule